// File: doc/BRIEF.md
# Display panel bring-up and standby sequencer

This block drives the power-up and standby control of an external display panel through a simple register-access port. A serial master, which is not part of this block, serves that port. After system reset the panel is held in reset. The first enable request starts a one-time start-up path. That path releases the panel reset and waits a programmable number of clock cycles. It then proves the link by writing a known pattern to a scratch register and reading it back. Next it reads the identification, mode and control registers, and finally takes the panel out of standby.

Once start-up has run, enable and disable requests take a short path instead. That path reads the control register, sets or clears the standby bit, and writes the result back. The results of start-up stay on registered outputs until the next system reset. These are the link-test result, the chip identity, the resolution code with a legality flag, and the resolution-control source. A `ready` output tells the host when a new request can be taken.

Top module: `panel_seq`

## Requirements
- R1: While and after system reset, and before any request, `panel_rst` is 1, `ready` is 1, `acc_valid` is 0, and `comm_ok`, `chip_id`, `chip_ver`, `res_code`, `res_legal` and `sw_ctrl` are all 0.
- R2: The first enable request drives `panel_rst` to 0. `acc_valid` does not rise until at least `WAIT_CYCLES` clock cycles after that. `panel_rst` never returns to 1 before the next system reset.
- R3: The first access of start-up writes `SCRATCH_PAT` (default 0x55) to register address 0, and the second access reads address 0 back. `comm_ok` is 1 only if the value read equals `SCRATCH_PAT`.
- R4: Start-up reads register address 1. Bits [7:4] of the value appear on `chip_id` and bits [3:0] on `chip_ver`.
- R5: Start-up reads register address 2, and bits [2:0] of the value appear on `res_code`. `res_legal` is 0 for codes 2 and 3, and 1 for codes 0, 1, 4, 5, 6 and 7.
- R6: Start-up reads register address 3, and bit 7 of the value appears on `sw_ctrl` (1 = software control, 0 = hardware control).
- R7: Enabling reads address 3, then writes back to address 3 the value read with bit 0 set and bits [7:1] unchanged. This step ends start-up.
- R8: A disable request, once start-up is done, reads address 3, then writes back to address 3 the value read with bit 0 cleared and bits [7:1] unchanged.
- R9: Start-up runs once per system reset. A later enable performs exactly two accesses (the read and write of address 3) and never writes address 0 again.
- R10: The block issues one access at a time. `acc_valid` stays at 1, with `acc_write` (1 = write), `acc_addr` and `acc_wdata` unchanged, until a cycle in which `acc_done` is 1. `acc_rdata` is taken in that cycle.
- R11: A disable request that arrives during start-up is held. It is carried out as an R8 sequence right after the enabling write, before `ready` returns to 1.
- R12: `ready` is 1 only when no sequence is running, and `acc_valid` is 0 whenever `ready` is 1. An enable request while `ready` is 0 is ignored. A disable request before the first enable is ignored. When enable and disable arrive in the same idle cycle, the enable is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| en_req | input | 1 | Enable request, sampled when high |
| dis_req | input | 1 | Disable (standby) request, sampled when high |
| ready | output | 1 | Sequencer idle, requests accepted |
| panel_rst | output | 1 | Panel reset, 1 = held in reset |
| acc_valid | output | 1 | Access request to the serial master |
| acc_write | output | 1 | 1 = write access, 0 = read access |
| acc_addr | output | ADDR_W | Panel register address |
| acc_wdata | output | 8 | Write data |
| acc_rdata | input | 8 | Read data, valid with acc_done |
| acc_done | input | 1 | One-cycle completion pulse from the serial master |
| comm_ok | output | 1 | Scratch loop-back matched |
| chip_id | output | 4 | Identification nibble |
| chip_ver | output | 4 | Version nibble |
| res_code | output | 3 | Resolution code |
| res_legal | output | 1 | Resolution code is a legal one |
| sw_ctrl | output | 1 | Resolution under software control |

## Verification
The bench builds the block with `WAIT_CYCLES` = 16 and `ADDR_W` = 6. With the settle time that short, a complete start-up finishes in a few dozen cycles. This lets every stimulus row restart from system reset, so the one-time path can be repeated with different register contents, including all illegal and several legal resolution codes and a broken loop-back. The short wait also leaves room to land a disable request inside the settle window, and to check the exact lower bound on the first access against the parameter.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   // Step of the sequencer; start-up steps precede the standby steps.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_SCR_WR,
      ST_SCR_RD,
      ST_IDENT_RD,
      ST_MODE_RD,
      ST_CTRL_RD,
      ST_SB_RD,
      ST_SB_WR
   } seq_state_e;

   localparam int unsigned REG_SCRATCH = 0;
   localparam int unsigned REG_IDENT   = 1;
   localparam int unsigned REG_MODE    = 2;
   localparam int unsigned REG_CTRL    = 3;
   localparam int unsigned PANEL_DW    = 8;

endpackage

// File: rtl/psq_delay.sv
module psq_delay #(
   parameter int unsigned CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   generate
      if (CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst_n;
         assign expired   = run;
      end else begin : g_cnt
         localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run)
               cnt <= '0;
            else if (!expired)
               cnt <= cnt + 1'b1;
         end

         assign expired = run && (cnt == CW'(CYCLES - 1));
      end
   endgenerate

endmodule

// File: rtl/psq_access.sv
module psq_access #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_wr,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [DATA_W-1:0] go_wdata,
   output logic              acc_valid,
   output logic              acc_write,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_done,
   input  logic [DATA_W-1:0] acc_rdata,
   output logic              fin,
   output logic [DATA_W-1:0] fin_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_write <= 1'b0;
         acc_addr  <= '0;
         acc_wdata <= '0;
         fin       <= 1'b0;
         fin_data  <= '0;
      end else begin
         fin <= 1'b0;
         if (acc_valid) begin
            if (acc_done) begin
               acc_valid <= 1'b0;
               fin       <= 1'b1;
               fin_data  <= acc_rdata;
            end
         end else if (go) begin
            acc_valid <= 1'b1;
            acc_write <= go_wr;
            acc_addr  <= go_addr;
            acc_wdata <= go_wdata;
         end
      end
   end

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
   import panel_seq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter logic [7:0]  SCRATCH_PAT = 8'h55
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_req,
   input  logic                dis_req,
   input  logic                expired,
   input  logic                fin,
   input  logic [PANEL_DW-1:0] fin_data,
   output logic                run_wait,
   output logic                go,
   output logic                go_wr,
   output logic [ADDR_W-1:0]   go_addr,
   output logic [PANEL_DW-1:0] go_wdata,
   output logic                ready,
   output logic                panel_rst,
   output logic                comm_ok,
   output logic [3:0]          chip_id,
   output logic [3:0]          chip_ver,
   output logic [2:0]          res_code,
   output logic                res_legal,
   output logic                sw_ctrl
);

   seq_state_e          state;
   logic                launched;
   logic                booted;
   logic                pend_dis;
   logic                sb_on;
   logic [PANEL_DW-1:0] sb_val;
   logic                is_access;

   assign is_access = (state != ST_IDLE) && (state != ST_SETTLE);
   assign go        = is_access && !launched;
   assign run_wait  = (state == ST_SETTLE);
   assign ready     = (state == ST_IDLE);

   always_comb begin
      go_wr    = 1'b0;
      go_addr  = ADDR_W'(REG_CTRL);
      go_wdata = '0;
      case (state)
         ST_SCR_WR: begin
            go_wr    = 1'b1;
            go_addr  = ADDR_W'(REG_SCRATCH);
            go_wdata = SCRATCH_PAT;
         end
         ST_SCR_RD:   go_addr = ADDR_W'(REG_SCRATCH);
         ST_IDENT_RD: go_addr = ADDR_W'(REG_IDENT);
         ST_MODE_RD:  go_addr = ADDR_W'(REG_MODE);
         ST_SB_WR: begin
            go_wr    = 1'b1;
            go_wdata = sb_val;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         launched  <= 1'b0;
         booted    <= 1'b0;
         pend_dis  <= 1'b0;
         sb_on     <= 1'b0;
         sb_val    <= '0;
         panel_rst <= 1'b1;
         comm_ok   <= 1'b0;
         chip_id   <= '0;
         chip_ver  <= '0;
         res_code  <= '0;
         res_legal <= 1'b0;
         sw_ctrl   <= 1'b0;
      end else begin
         if (dis_req && !booted && state != ST_IDLE)
            pend_dis <= 1'b1;
         if (go)
            launched <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (en_req) begin
                  sb_on <= 1'b1;
                  if (booted) begin
                     state <= ST_SB_RD;
                  end else begin
                     panel_rst <= 1'b0;
                     state     <= ST_SETTLE;
                  end
               end else if (dis_req && booted) begin
                  sb_on <= 1'b0;
                  state <= ST_SB_RD;
               end
            end
            ST_SETTLE: if (expired) state <= ST_SCR_WR;
            default: if (fin) begin
               launched <= 1'b0;
               case (state)
                  ST_SCR_WR: state <= ST_SCR_RD;
                  ST_SCR_RD: begin
                     comm_ok <= (fin_data == SCRATCH_PAT);
                     state   <= ST_IDENT_RD;
                  end
                  ST_IDENT_RD: begin
                     chip_id  <= fin_data[7:4];
                     chip_ver <= fin_data[3:0];
                     state    <= ST_MODE_RD;
                  end
                  ST_MODE_RD: begin
                     res_code  <= fin_data[2:0];
                     res_legal <= (fin_data[2:1] != 2'b01);
                     state     <= ST_CTRL_RD;
                  end
                  ST_CTRL_RD: begin
                     sw_ctrl <= fin_data[7];
                     state   <= ST_SB_RD;
                  end
                  ST_SB_RD: begin
                     sb_val <= {fin_data[7:1], sb_on};
                     state  <= ST_SB_WR;
                  end
                  default: begin
                     booted <= 1'b1;
                     if (pend_dis || (dis_req && !booted)) begin
                        pend_dis <= 1'b0;
                        sb_on    <= 1'b0;
                        state    <= ST_SB_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/panel_seq.sv
module panel_seq #(
   parameter int unsigned WAIT_CYCLES = 250000,
   parameter int unsigned ADDR_W      = 6,
   parameter logic [7:0]  SCRATCH_PAT = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic              dis_req,
   output logic              ready,
   output logic              panel_rst,
   output logic              acc_valid,
   output logic              acc_write,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [7:0]        acc_wdata,
   input  logic [7:0]        acc_rdata,
   input  logic              acc_done,
   output logic              comm_ok,
   output logic [3:0]        chip_id,
   output logic [3:0]        chip_ver,
   output logic [2:0]        res_code,
   output logic              res_legal,
   output logic              sw_ctrl
);

   localparam int unsigned DW = panel_seq_pkg::PANEL_DW;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("panel_seq: ADDR_W must lie in 2..16");
      end
   endgenerate

   logic              expired;
   logic              run_wait;
   logic              go;
   logic              go_wr;
   logic [ADDR_W-1:0] go_addr;
   logic [DW-1:0]     go_wdata;
   logic              fin;
   logic [DW-1:0]     fin_data;

   psq_delay #(.CYCLES(WAIT_CYCLES)) u_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_wait),
      .expired (expired)
   );

   psq_access #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_access (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_wr     (go_wr),
      .go_addr   (go_addr),
      .go_wdata  (go_wdata),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_done  (acc_done),
      .acc_rdata (acc_rdata),
      .fin       (fin),
      .fin_data  (fin_data)
   );

   psq_ctrl #(.ADDR_W(ADDR_W), .SCRATCH_PAT(SCRATCH_PAT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_req    (en_req),
      .dis_req   (dis_req),
      .expired   (expired),
      .fin       (fin),
      .fin_data  (fin_data),
      .run_wait  (run_wait),
      .go        (go),
      .go_wr     (go_wr),
      .go_addr   (go_addr),
      .go_wdata  (go_wdata),
      .ready     (ready),
      .panel_rst (panel_rst),
      .comm_ok   (comm_ok),
      .chip_id   (chip_id),
      .chip_ver  (chip_ver),
      .res_code  (res_code),
      .res_legal (res_legal),
      .sw_ctrl   (sw_ctrl)
   );

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk #(
   parameter int unsigned WAIT_CYCLES = 250000,
   parameter int unsigned ADDR_W      = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              panel_rst,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic              acc_done
);

   // Cycles since the panel reset was released, saturating at the window.
   logic [31:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap <= '0;
      else if (panel_rst)
         gap <= '0;
      else if (gap < WAIT_CYCLES)
         gap <= gap + 1;
   end

   a_r2_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_valid) |-> (gap >= WAIT_CYCLES));

   a_r2_no_access_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> !panel_rst);

   a_r2_reset_not_reasserted: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(panel_rst));

   a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_done) |=> (acc_valid && $stable(acc_addr)
                                    && $stable(acc_write) && $stable(acc_wdata)));

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !acc_valid);

endmodule

bind panel_seq panel_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (ready),
   .panel_rst (panel_rst),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .acc_done  (acc_done)
);

// File: tb/panel_seq_tb_top.sv
`timescale 1ns/1ps
module panel_seq_tb_top;

   localparam int unsigned WAIT = 16;
   localparam int unsigned AW   = 6;
   localparam int unsigned NVEC = 8;

   // {ident, mode, ctrl, corrupt, ok, id, ver, res, legal, sw, ctrl_final}
   localparam logic [46:0] VEC [0:NVEC-1] = '{
      {8'h5A, 8'h07, 8'h80, 1'b0, 1'b1, 4'h5, 4'hA, 3'd7, 1'b1, 1'b1, 8'h81},
      {8'h12, 8'hFA, 8'h00, 1'b0, 1'b1, 4'h1, 4'h2, 3'd2, 1'b0, 1'b0, 8'h01},
      {8'hC3, 8'h0B, 8'h7E, 1'b1, 1'b0, 4'hC, 4'h3, 3'd3, 1'b0, 1'b0, 8'h7F},
      {8'h00, 8'h04, 8'hFF, 1'b0, 1'b1, 4'h0, 4'h0, 3'd4, 1'b1, 1'b1, 8'hFF},
      {8'hFF, 8'h01, 8'h41, 1'b0, 1'b1, 4'hF, 4'hF, 3'd1, 1'b1, 1'b0, 8'h41},
      {8'h37, 8'h00, 8'h06, 1'b0, 1'b1, 4'h3, 4'h7, 3'd0, 1'b1, 1'b0, 8'h07},
      {8'hA0, 8'h0D, 8'hC2, 1'b0, 1'b1, 4'hA, 4'h0, 3'd5, 1'b1, 1'b1, 8'hC3},
      {8'h09, 8'h0E, 8'h01, 1'b0, 1'b1, 4'h0, 4'h9, 3'd6, 1'b1, 1'b0, 8'h01}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_req = 1'b0;
   logic          dis_req = 1'b0;
   logic          ready, panel_rst, acc_valid, acc_write;
   logic [AW-1:0] acc_addr;
   logic [7:0]    acc_wdata, acc_rdata;
   logic          acc_done;
   logic          comm_ok, res_legal, sw_ctrl;
   logic [3:0]    chip_id, chip_ver;
   logic [2:0]    res_code;

   always #2 clk = ~clk;

   panel_seq #(.WAIT_CYCLES(WAIT), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .ready(ready), .panel_rst(panel_rst), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .acc_done(acc_done), .comm_ok(comm_ok),
      .chip_id(chip_id), .chip_ver(chip_ver), .res_code(res_code),
      .res_legal(res_legal), .sw_ctrl(sw_ctrl)
   );

   // Panel model serving the access port.
   logic [7:0] cfg_id = 8'h00, cfg_mode = 8'h00, cfg_ctl = 8'h00;
   logic       cfg_corrupt = 1'b0;
   logic [7:0] m_reg [0:3];
   logic       m_busy, m_done;
   logic [1:0] m_lat;
   logic [7:0] m_rdata;
   int         acc_cnt, scr_wr_cnt;

   assign acc_done  = m_done;
   assign acc_rdata = m_rdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg[0] <= 8'h00; m_reg[1] <= cfg_id;
         m_reg[2] <= cfg_mode; m_reg[3] <= cfg_ctl;
         m_busy <= 1'b0; m_done <= 1'b0; m_lat <= 2'd0; m_rdata <= 8'h00;
         acc_cnt <= 0; scr_wr_cnt <= 0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_lat == 2'd0) begin
               m_busy  <= 1'b0;
               m_done  <= 1'b1;
               acc_cnt <= acc_cnt + 1;
               if (acc_write) begin
                  if (acc_addr == 0) begin
                     scr_wr_cnt <= scr_wr_cnt + 1;
                     m_reg[0] <= cfg_corrupt ? (acc_wdata ^ 8'h01) : acc_wdata;
                  end else begin
                     m_reg[acc_addr[1:0]] <= acc_wdata;
                  end
               end else begin
                  m_rdata <= m_reg[acc_addr[1:0]];
               end
            end else begin
               m_lat <= m_lat - 2'd1;
            end
         end else if (acc_valid && !m_done) begin
            m_busy <= 1'b1;
            m_lat  <= 2'd3;
         end
      end
   end

   // Gap between reset release and the first access.
   int   gap_cnt, first_gap;
   logic seen_acc;
   always @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= 0; first_gap <= 0; seen_acc <= 1'b0;
      end else if (!panel_rst && !seen_acc) begin
         if (acc_valid) begin
            seen_acc  <= 1'b1;
            first_gap <= gap_cnt;
         end else begin
            gap_cnt <= gap_cnt + 1;
         end
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] id, input logic [7:0] md,
                           input logic [7:0] ct, input logic cor);
      @(negedge clk);
      rst_n = 1'b0; en_req = 1'b0; dis_req = 1'b0;
      cfg_id = id; cfg_mode = md; cfg_ctl = ct; cfg_corrupt = cor;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse(input logic en, input logic dis);
      en_req = en; dis_req = dis;
      @(negedge clk);
      en_req = 1'b0; dis_req = 1'b0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2000; i++) begin
         if (ready) return;
         @(negedge clk);
      end
      chk("R12", "ready timeout", 0, 1);
   endtask

   initial begin
      int base, scr_base;

      // R1 reset state
      do_reset(8'h5A, 8'h07, 8'h80, 1'b0);
      chk("R1", "panel_rst", panel_rst, 1);
      chk("R1", "ready", ready, 1);
      chk("R1", "acc_valid", acc_valid, 0);
      chk("R1", "status", {comm_ok, chip_id, chip_ver, res_code, res_legal, sw_ctrl}, 0);

      // R12 disable before first enable is ignored
      pulse(1'b0, 1'b1);
      repeat (WAIT + 8) @(negedge clk);
      chk("R12", "early disable accesses", acc_cnt, 0);
      chk("R12", "early disable panel_rst", panel_rst, 1);
      chk("R12", "early disable ready", ready, 1);

      // Table of start-up cases (R2..R7)
      for (int v = 0; v < NVEC; v++) begin
         logic [46:0] e;
         e = VEC[v];
         do_reset(e[46:39], e[38:31], e[30:23], e[22]);
         pulse(1'b1, 1'b0);
         wait_ready();
         chk("R2", "panel_rst released", panel_rst, 0);
         chk("R2", "settle gap", (first_gap >= int'(WAIT)) ? 1 : 0, 1);
         chk("R3", "comm_ok", comm_ok, e[21]);
         chk("R3", "scratch writes", scr_wr_cnt, 1);
         chk("R4", "chip_id", chip_id, e[20:17]);
         chk("R4", "chip_ver", chip_ver, e[16:13]);
         chk("R5", "res_code", res_code, e[12:10]);
         chk("R5", "res_legal", res_legal, e[9]);
         chk("R6", "sw_ctrl", sw_ctrl, e[8]);
         chk("R7", "ctrl after enable", m_reg[3], e[7:0]);
         chk("R7", "start-up access count", acc_cnt, 7);
      end

      // R8 / R9 / R12 after start-up
      do_reset(8'h5A, 8'h07, 8'h80, 1'b0);
      pulse(1'b1, 1'b0);
      wait_ready();
      base = acc_cnt; scr_base = scr_wr_cnt;
      pulse(1'b0, 1'b1);
      wait_ready();
      chk("R8", "ctrl after disable", m_reg[3], 8'h80);
      chk("R8", "disable accesses", acc_cnt - base, 2);
      base = acc_cnt;
      pulse(1'b1, 1'b0);
      @(negedge clk);
      pulse(1'b1, 1'b0);   // arrives while busy: ignored
      wait_ready();
      chk("R9", "re-enable accesses", acc_cnt - base, 2);
      chk("R9", "no new scratch write", scr_wr_cnt - scr_base, 0);
      chk("R9", "ctrl after re-enable", m_reg[3], 8'h81);
      chk("R9", "comm_ok kept", comm_ok, 1);
      pulse(1'b0, 1'b1);
      wait_ready();
      base = acc_cnt;
      pulse(1'b1, 1'b1);   // same cycle: enable wins
      wait_ready();
      chk("R12", "enable wins", m_reg[3], 8'h81);
      chk("R12", "same-cycle accesses", acc_cnt - base, 2);

      // R11 disable during start-up
      do_reset(8'h21, 8'h06, 8'hA5, 1'b0);
      pulse(1'b1, 1'b0);
      repeat (4) @(negedge clk);
      chk("R12", "busy during settle", ready, 0);
      pulse(1'b0, 1'b1);
      wait_ready();
      chk("R11", "held disable executed", m_reg[3], 8'hA4);
      chk("R11", "total accesses", acc_cnt, 9);
      chk("R11", "start-up results kept", {chip_id, chip_ver}, 8'h21);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule